// File: doc/BRIEF.md
# Fetch Address Sequencer with Trap and Halt Control

This block owns the fetch address of a 16-bit pipelined processor. The program counter lives here, outside the register file. Each clock the block picks the next fetch address from one of several sources. The default is a sequential step to the next 16-bit instruction, because every branch is assumed not taken. The other sources are a branch or jump target that a later stage has resolved as taken, the fixed trap handler address, and the saved exception address.

When decode flags an unknown opcode, the block records the faulting fetch address in an exception PC register and moves fetch to the handler. A return-from-interrupt flag sends fetch back to the address held in that register. A halt flag moves the block into a halted state. In that state the fetch address and the exception PC are frozen and every input is ignored until reset. Two states drive the control. `ST_RUN` is normal sequencing. `ST_HALTED` is the frozen state. The only transition is `RUN_TO_HALTED`, which happens when a halt is accepted. Reset is the only way back to `ST_RUN`.

Top module: `pc_seq_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and on the first cycle after it, `pc_o` is 0x0000, `epc_o` is 0x0000 and `halted_o` is 0.
- R2: In `ST_RUN`, when none of `stall_i`, `redirect_i`, `illegal_i`, `rti_i` and `halt_i` is set, `pc_o` advances by 2 on the next cycle and wraps modulo 2^16.
- R3: In `ST_RUN`, `stall_i` without `illegal_i`, `rti_i` or `redirect_i` holds `pc_o` unchanged.
- R4: In `ST_RUN`, `redirect_i` without `illegal_i` or `rti_i` loads `target_i` into `pc_o` on the next cycle, even when `stall_i` is set.
- R5: In `ST_RUN`, `illegal_i` loads 0x0002 into `pc_o` and the current `pc_o` into `epc_o` on the next cycle. It wins over every other input.
- R6: In `ST_RUN`, `rti_i` without `illegal_i` loads the current `epc_o` into `pc_o` on the next cycle. It wins over `redirect_i`, `stall_i` and `halt_i`.
- R7: In `ST_RUN`, `halt_i` with none of `stall_i`, `redirect_i`, `illegal_i` and `rti_i` sets `halted_o` on the next cycle and leaves `pc_o` unchanged.
- R8: In `ST_HALTED`, `pc_o`, `epc_o` and `halted_o` stay unchanged whatever the inputs, until reset.
- R9: A `halt_i` that arrives together with `stall_i` (and no higher-priority input) is not taken: `halted_o` stays 0 and `pc_o` holds.
- R10: `epc_o` changes only on a cycle that follows an accepted `illegal_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold the fetch address this cycle |
| redirect_i | input | 1 | A taken branch or jump has been resolved |
| target_i | input | 16 | Target address for `redirect_i` |
| illegal_i | input | 1 | Unknown opcode detected |
| rti_i | input | 1 | Return-from-interrupt instruction |
| halt_i | input | 1 | Halt instruction |
| pc_o | output | 16 | Current fetch address |
| epc_o | output | 16 | Saved exception address |
| halted_o | output | 1 | Block is in `ST_HALTED` |

## Verification
The bound assertions check every clock. They cover the one-cycle effect of each source: sequential step, stall hold, redirect, trap with exception PC capture, and resume. They also check that the halted state is permanent and that the exception PC stays stable except after a trap. The bench's behavioural model shows the rest. This includes the full priority order when several flags are raised together, halts that are refused under stall, address wrap at the top of memory, a trap and resume round trip, and reset recovering the block from the halted state.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_SEQ    = 3'd1,
        SRC_BRANCH = 3'd2,
        SRC_TRAP   = 3'd3,
        SRC_RESUME = 3'd4
    } pc_src_e;

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic       frozen_i,
    input  logic       stall_i,
    input  logic       redirect_i,
    input  logic       illegal_i,
    input  logic       rti_i,
    input  logic       halt_i,
    output pc_src_e    src_o,
    output logic       halt_take_o
);

    // Fixed priority: trap, resume, branch, stall, halt, sequential.
    always_comb begin
        src_o       = SRC_SEQ;
        halt_take_o = 1'b0;
        if (frozen_i) begin
            src_o = SRC_HOLD;
        end else if (illegal_i) begin
            src_o = SRC_TRAP;
        end else if (rti_i) begin
            src_o = SRC_RESUME;
        end else if (redirect_i) begin
            src_o = SRC_BRANCH;
        end else if (stall_i) begin
            src_o = SRC_HOLD;
        end else if (halt_i) begin
            src_o       = SRC_HOLD;
            halt_take_o = 1'b1;
        end
    end

endmodule

// File: rtl/pcseq_fsm.sv
module pcseq_fsm
    import pcseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_take_i,
    output logic frozen_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (halt_take_i) state_d = ST_HALTED;  // RUN_TO_HALTED
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:    frozen_o = 1'b0;
            ST_HALTED: frozen_o = 1'b1;
            default:   frozen_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcseq_epc.sv
module pcseq_epc #(
    parameter int          ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] epc_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         epc_o <= RESET_VAL;
        else if (capture_i) epc_o <= pc_i;
    end

endmodule

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
    import pcseq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int INSTR_BYTES = 2,
    parameter int RESET_PC    = 0,
    parameter int TRAP_VEC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              illegal_i,
    input  logic              rti_i,
    input  logic              halt_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] epc_o,
    output logic              halted_o
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(RESET_PC);
    localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(TRAP_VEC);

    pc_src_e           src;
    logic              halt_take;
    logic              frozen;
    logic [ADDR_W-1:0] pc_d;

    pcseq_arbiter u_arb (
        .frozen_i    (frozen),
        .stall_i     (stall_i),
        .redirect_i  (redirect_i),
        .illegal_i   (illegal_i),
        .rti_i       (rti_i),
        .halt_i      (halt_i),
        .src_o       (src),
        .halt_take_o (halt_take)
    );

    pcseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_take_i (halt_take),
        .frozen_o    (frozen)
    );

    pcseq_epc #(.ADDR_W(ADDR_W), .RESET_VAL('0)) u_epc (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (src == SRC_TRAP),
        .pc_i      (pc_o),
        .epc_o     (epc_o)
    );

    always_comb begin
        unique case (src)
            SRC_HOLD:   pc_d = pc_o;
            SRC_SEQ:    pc_d = pc_o + STEP;
            SRC_BRANCH: pc_d = target_i;
            SRC_TRAP:   pc_d = VEC_ADDR;
            SRC_RESUME: pc_d = epc_o;
            default:    pc_d = pc_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_o <= RST_ADDR;
        else        pc_o <= pc_d;
    end

    assign halted_o = frozen;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int ADDR_W      = 16,
    parameter int INSTR_BYTES = 2,
    parameter int TRAP_VEC    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall_i,
    input logic              redirect_i,
    input logic [ADDR_W-1:0] target_i,
    input logic              illegal_i,
    input logic              rti_i,
    input logic              halt_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] epc_o,
    input logic              halted_o
);

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && !stall_i && !redirect_i && !illegal_i && !rti_i && !halt_i)
        |=> pc_o == ADDR_W'($past(pc_o) + ADDR_W'(INSTR_BYTES)));

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && stall_i && !redirect_i && !illegal_i && !rti_i)
        |=> $stable(pc_o));

    a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && redirect_i && !illegal_i && !rti_i)
        |=> pc_o == $past(target_i));

    a_r5_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && illegal_i)
        |=> (pc_o == ADDR_W'(TRAP_VEC)) && (epc_o == $past(pc_o)));

    a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && rti_i && !illegal_i)
        |=> pc_o == $past(epc_o));

    a_r7_halt_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && halt_i && !stall_i && !redirect_i && !illegal_i && !rti_i)
        |=> halted_o && $stable(pc_o));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o && $stable(pc_o) && $stable(epc_o));

    a_r10_epc_only_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o || !illegal_i) |=> $stable(epc_o));

endmodule

bind pc_seq_ctrl pcseq_chk #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .TRAP_VEC    (TRAP_VEC)
) u_pcseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .redirect_i (redirect_i),
    .target_i   (target_i),
    .illegal_i  (illegal_i),
    .rti_i      (rti_i),
    .halt_i     (halt_i),
    .pc_o       (pc_o),
    .epc_o      (epc_o),
    .halted_o   (halted_o)
);

// File: tb/tb_pc_seq_ctrl.sv
module tb_pc_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0, redirect_i = 1'b0, illegal_i = 1'b0;
    logic        rti_i = 1'b0, halt_i = 1'b0;
    logic [15:0] target_i = '0;
    logic [15:0] pc_o, epc_o;
    logic        halted_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural reference state
    logic [15:0] m_pc = 16'h0000, m_epc = 16'h0000;
    bit          m_halt = 0;
    string       tag = "R1";

    always #5 clk = ~clk;

    pc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .redirect_i(redirect_i),
        .target_i(target_i), .illegal_i(illegal_i), .rti_i(rti_i), .halt_i(halt_i),
        .pc_o(pc_o), .epc_o(epc_o), .halted_o(halted_o)
    );

    // reference model: one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 16'h0000; m_epc = 16'h0000; m_halt = 0; tag = "R1";
        end else if (m_halt) begin
            tag = "R8";
        end else if (illegal_i) begin
            m_epc = m_pc; m_pc = 16'h0002; tag = "R5";
        end else if (rti_i) begin
            m_pc = m_epc; tag = "R6";
        end else if (redirect_i) begin
            m_pc = target_i; tag = "R4";
        end else if (stall_i) begin
            tag = halt_i ? "R9" : "R3";
        end else if (halt_i) begin
            m_halt = 1; tag = "R7";
        end else begin
            m_pc = m_pc + 16'd2; tag = "R2";
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (pc_o !== m_pc) begin
                errors++;
                $display("FAIL %s pc_o actual=%h expected=%h", tag, pc_o, m_pc);
            end
            if (epc_o !== m_epc) begin
                errors++;
                $display("FAIL %s epc_o actual=%h expected=%h",
                         (tag == "R5") ? "R5" : "R10", epc_o, m_epc);
            end
            if (halted_o !== m_halt) begin
                errors++;
                $display("FAIL %s halted_o actual=%b expected=%b", tag, halted_o, m_halt);
            end
        end
    end

    task automatic drive(input bit s, input bit r, input logic [15:0] t,
                         input bit il, input bit ri, input bit h);
        @(negedge clk);
        stall_i = s; redirect_i = r; target_i = t;
        illegal_i = il; rti_i = ri; halt_i = h;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stall_i = 0; redirect_i = 0; illegal_i = 0; rti_i = 0; halt_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state observed over two cycles
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: sequential stepping
        repeat (4) drive(0, 0, 16'h0, 0, 0, 0);
        // R3: stall holds
        repeat (2) drive(1, 0, 16'h0, 0, 0, 0);
        // R4: redirect, also under stall
        drive(0, 1, 16'h1234, 0, 0, 0);
        drive(1, 1, 16'hFFFC, 0, 0, 0);
        // R2: wrap at top of memory
        repeat (3) drive(0, 0, 16'h0, 0, 0, 0);
        // R5: trap beats everything, captures PC
        drive(1, 1, 16'h4444, 0, 0, 0);
        drive(1, 1, 16'h9999, 1, 1, 1);
        repeat (2) drive(0, 0, 16'h0, 0, 0, 0);
        // R6: resume beats redirect and halt
        drive(1, 1, 16'h7777, 0, 1, 1);
        drive(0, 0, 16'h0, 0, 0, 0);
        // R9: halt under stall refused
        drive(1, 0, 16'h0, 0, 0, 1);
        drive(0, 0, 16'h0, 0, 0, 0);
        // R7: halt accepted
        drive(0, 0, 16'h0, 0, 0, 1);
        // R8: everything ignored while halted
        drive(0, 1, 16'hAAAA, 0, 0, 0);
        drive(0, 0, 16'h0, 1, 0, 0);
        drive(0, 0, 16'h0, 0, 1, 0);
        drive(0, 0, 16'h0, 0, 0, 0);
        // R1: reset leaves the halted state
        do_reset();
        drive(0, 0, 16'h0, 0, 0, 0);
        // random mix, with rare halts and periodic resets
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 96) begin
                do_reset();
            end else begin
                drive(($urandom % 4) == 0, ($urandom % 6) == 0, 16'($urandom),
                      ($urandom % 12) == 0, ($urandom % 10) == 0,
                      ($urandom % 40) == 0);
            end
        end
        drive(0, 0, 16'h0, 0, 0, 0);
        @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule